// File: doc/BRIEF.md
# Programmable Parallel Port Register Interface

This block is the processor-facing register core of a 24-line parallel I/O controller. A host reaches it through an asynchronous-style strobe bus: an active-low select, an active-low read, an active-low write and a 2-bit address. The address picks one of three port latches or the control register. The lines are grouped as two 8-bit ports, A and B, plus port C, which is split into an upper and a lower 4-bit half. Each of the four groups has its own direction, and its output enables follow that direction.

The control address takes two kinds of command, told apart by data bit 7. A configuration word (bit 7 = 1) selects the group modes and the four directions. It also clears every output latch and sends a one-cycle pulse to the neighbouring handshake blocks. A single-bit command (bit 7 = 0) sets or clears one port C output bit. The host never has to read, modify and write the port. The configuration word can be read back. The group mode fields are exported to the strobed and bidirectional sequencing logic, which sits outside this block. Reset leaves every port as an input, so no set-up is needed to use the lines as inputs.

All logic runs on one clock. The bus strobes are sampled on that clock, and both the read data and its drive enable are registered.

Top module: `ppi_regif`

## Requirements
- R1: After synchronous reset all output enables are 0, all output latches are 0, the read-data enable is 0 and the configuration word reads back as 0x9B.
- R2: The read-data enable is 1 in the cycle after a clock edge at which select and read were both sampled low, and 0 in the cycle after any other edge.
- R3: A write is held while select and write are low and takes effect at the first clock edge at which write is sampled high again. No target changes while write is still low, and a write strobe with select high changes nothing.
- R4: A control-address write with bit 7 = 1 stores the byte, and a control-address read then returns that same byte.
- R5: In the configuration word, a direction bit of 1 means input and 0 means output. Bit 4 sets the enables of port A, bit 3 those of port C bits 7:4, bit 1 those of port B and bit 0 those of port C bits 3:0. All enables of a group are equal.
- R6: Loading a configuration word clears the port A, B and C latches and raises cfg_load for exactly one cycle.
- R7: A control-address write with bit 7 = 0 drives port C latch bit number data[3:1] to data[0]. It leaves the other port C bits and the stored configuration word unchanged.
- R8: A read of address 0, 1 or 2 returns port A, B or C. For each bit the result is the output latch where that bit is enabled and the input pin where it is not. Address 3 returns the configuration word.
- R9: mode_a equals configuration bits 6:5 and mode_b equals configuration bit 2.
- R10: A write to address 0, 1 or 2 loads the whole byte into that port's latch, whatever the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, commits on return high |
| addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | Registered drive enable for rdata |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, upper and lower half |
| mode_a | output | 2 | Group A mode field for the handshake logic |
| mode_b | output | 1 | Group B mode field for the handshake logic |
| cfg_load | output | 1 | One-cycle pulse when a configuration word is loaded |

## Verification
The hardest situation to reach is the one where a port bit is enabled and its pin disagrees with its latch. This must hold in every direction combination at once, so that the read path's per-bit choice is actually exercised. The stimulus steps through all 16 direction patterns. For each one it loads latches that differ from the pins and reads all three ports. It then sweeps every single-bit command over a known port C pattern and confirms that only the addressed bit moves. The commit edge is probed by holding write low over several clocks and sampling the latch in between.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // configuration word; a direction bit of 1 means input
  typedef struct packed {
    logic       is_cfg;
    logic [1:0] mode_a;
    logic       a_in;
    logic       cu_in;
    logic       mode_b;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam logic [DATA_W-1:0] CFG_RESET = 8'h9B;
endpackage

// File: rtl/ppi_bus_strobe.sv
module ppi_bus_strobe #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!wr_n && !cs_n) begin
      pend_q <= 1'b1;
      addr_q <= addr;
      data_q <= wdata;
    end else if (wr_n) begin
      pend_q <= 1'b0;
    end
  end

  // the held write lands at the first edge that sees write released
  assign commit = pend_q && wr_n;
  assign c_addr = addr_q;
  assign c_data = data_q;
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned IW = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  output cfg_t              cfg_q,
  output logic              cfg_ld,
  output logic              bit_ld,
  output logic [IW-1:0]     bit_idx,
  output logic              bit_val
);
  logic to_ctrl;

  assign to_ctrl = commit && (sel_e'(c_addr) == SEL_CTRL);
  assign cfg_ld  = to_ctrl &&  c_data[DATA_W-1];
  assign bit_ld  = to_ctrl && !c_data[DATA_W-1];
  assign bit_idx = c_data[IW:1];
  assign bit_val = c_data[0];

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= cfg_t'(CFG_RESET);
    else if (cfg_ld) cfg_q <= cfg_t'(c_data);
  end
endmodule

// File: rtl/ppi_port_latch.sv
module ppi_port_latch #(
  parameter int unsigned W       = 8,
  parameter bit          BIT_OPS = 1'b0,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          bit_en,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  q
);
  logic [W-1:0] bit_next;
  logic         bit_go;

  assign bit_go = bit_en && BIT_OPS;

  always_comb begin
    bit_next          = q;
    bit_next[bit_idx] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (wr_en)  q <= wr_data;
    else if (bit_go) q <= bit_next;
  end
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
  import ppi_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic [ADDR_W-1:0] sel,
  input  logic [PORT_W-1:0] pa_q,
  input  logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pa_in,
  input  logic [PORT_W-1:0] pb_q,
  input  logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pb_in,
  input  logic [PORT_W-1:0] pc_q,
  input  logic [PORT_W-1:0] pc_oe,
  input  logic [PORT_W-1:0] pc_in,
  input  cfg_t              cfg,
  output logic [PORT_W-1:0] rd_d
);
  logic [PORT_W-1:0] a_v, b_v, c_v;

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    assign a_v[i] = pa_oe[i] ? pa_q[i] : pa_in[i];
    assign b_v[i] = pb_oe[i] ? pb_q[i] : pb_in[i];
    assign c_v[i] = pc_oe[i] ? pc_q[i] : pc_in[i];
  end

  always_comb begin
    unique case (sel_e'(sel))
      SEL_A:   rd_d = a_v;
      SEL_B:   rd_d = b_v;
      SEL_C:   rd_d = c_v;
      default: rd_d = PORT_W'(cfg);
    endcase
  end
endmodule

// File: rtl/ppi_regif.sv
module ppi_regif
  import ppi_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned HALF_W = PORT_W / 2,
  localparam int unsigned IW     = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe,
  output logic [1:0]        mode_a,
  output logic              mode_b,
  output logic              cfg_load
);
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [PORT_W-1:0] c_data;
  cfg_t              cfg_q;
  logic              cfg_ld, bit_ld, bit_val;
  logic [IW-1:0]     bit_idx;
  logic              wr_a, wr_b, wr_c;
  logic [PORT_W-1:0] rd_d;

  ppi_bus_strobe #(.AW(ADDR_W), .DW(PORT_W)) u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .commit(commit), .c_addr(c_addr), .c_data(c_data)
  );

  ppi_ctrl_reg #(.PORT_W(PORT_W)) u_ctrl (
    .clk(clk), .rst(rst), .commit(commit), .c_addr(c_addr), .c_data(c_data),
    .cfg_q(cfg_q), .cfg_ld(cfg_ld), .bit_ld(bit_ld), .bit_idx(bit_idx),
    .bit_val(bit_val)
  );

  assign wr_a = commit && (sel_e'(c_addr) == SEL_A);
  assign wr_b = commit && (sel_e'(c_addr) == SEL_B);
  assign wr_c = commit && (sel_e'(c_addr) == SEL_C);

  ppi_port_latch #(.W(PORT_W), .BIT_OPS(1'b0)) u_pa (
    .clk(clk), .rst(rst), .clr(cfg_ld), .wr_en(wr_a), .wr_data(c_data),
    .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out)
  );
  ppi_port_latch #(.W(PORT_W), .BIT_OPS(1'b0)) u_pb (
    .clk(clk), .rst(rst), .clr(cfg_ld), .wr_en(wr_b), .wr_data(c_data),
    .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out)
  );
  ppi_port_latch #(.W(PORT_W), .BIT_OPS(1'b1)) u_pc (
    .clk(clk), .rst(rst), .clr(cfg_ld), .wr_en(wr_c), .wr_data(c_data),
    .bit_en(bit_ld), .bit_idx(bit_idx), .bit_val(bit_val), .q(pc_out)
  );

  assign pa_oe = {PORT_W{~cfg_q.a_in}};
  assign pb_oe = {PORT_W{~cfg_q.b_in}};
  assign pc_oe = {{HALF_W{~cfg_q.cu_in}}, {HALF_W{~cfg_q.cl_in}}};
  assign mode_a = cfg_q.mode_a;
  assign mode_b = cfg_q.mode_b;

  ppi_read_mux #(.PORT_W(PORT_W)) u_rmux (
    .sel(addr), .pa_q(pa_out), .pa_oe(pa_oe), .pa_in(pa_in),
    .pb_q(pb_out), .pb_oe(pb_oe), .pb_in(pb_in),
    .pc_q(pc_out), .pc_oe(pc_oe), .pc_in(pc_in),
    .cfg(cfg_q), .rd_d(rd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
      cfg_load <= 1'b0;
    end else begin
      rdata    <= rd_d;
      rdata_oe <= !cs_n && !rd_n;
      cfg_load <= cfg_ld;
    end
  end
endmodule

// File: rtl/ppi_regif_chk.sv
module ppi_regif_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       rdata_oe,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_oe,
  input logic       cfg_load,
  input logic       bit_ld,
  input logic       cfg_ld,
  input logic [7:0] c_data,
  input logic [7:0] cfg_word
);
  // R1
  a_r1_reset_inputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 && cfg_word == 8'h9B));
  // R2
  a_r2_oe_on_read: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n) |=> rdata_oe);
  a_r2_oe_off: assert property (@(posedge clk) disable iff (rst)
    !(!cs_n && !rd_n) |=> !rdata_oe);
  // R3
  a_r3_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));
  // R4
  a_r4_cfg_stored: assert property (@(posedge clk) disable iff (rst)
    cfg_ld |=> cfg_word == $past(c_data));
  // R6
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !cfg_load);
  // R7
  a_r7_one_bit: assert property (@(posedge clk) disable iff (rst)
    bit_ld |=> ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(cfg_word)
                && $stable(pa_out) && $stable(pb_out)));
endmodule

bind ppi_regif ppi_regif_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .rdata_oe(rdata_oe), .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe), .cfg_load(cfg_load),
  .bit_ld(bit_ld), .cfg_ld(cfg_ld), .c_data(c_data), .cfg_word(cfg_q)
);

// File: tb/ppi_regif_tb.sv
module ppi_regif_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic rdata_oe, mode_b, cfg_load;
  logic [1:0] mode_a;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  ppi_regif u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .mode_a(mode_a), .mode_b(mode_b), .cfg_load(cfg_load)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write, returns at negedge after the commit edge; pulse_seen = cfg_load then
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, output bit pulse_seen);
    @(negedge clk); cs_n = 1'b0; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    pulse_seen = cfg_load;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output bit oe_seen);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk); d = rdata; oe_seen = rdata_oe;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  initial begin
    logic [7:0] r, pc_exp, ra, rb, rc;
    bit oe, p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(pa_oe == 0 && pb_oe == 0 && pc_oe == 0, "R1 oe", {pa_oe, pb_oe, pc_oe}, 0);
    chk(pa_out == 0 && pb_out == 0 && pc_out == 0, "R1 latch", {pa_out, pb_out, pc_out}, 0);
    chk(rdata_oe == 0, "R1 rdata_oe", rdata_oe, 0);
    bus_read(2'd3, r, oe);
    chk(r == 8'h9B, "R1 cfg", r, 8'h9B);
    // R2
    chk(oe == 1'b1, "R2 oe during read", oe, 1);
    @(negedge clk);
    chk(rdata_oe == 1'b0, "R2 oe after read", rdata_oe, 0);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk(rdata_oe == 1'b0, "R2 no select", rdata_oe, 0);
    rd_n = 1'b1;

    // R4 R5 R9 R6: every configuration word
    for (int m = 0; m < 128; m++) begin
      logic [7:0] w;
      w = 8'h80 | 8'(m);
      bus_write(2'd3, w, p);
      chk(p == 1'b1, "R6 cfg_load pulse", p, 1);
      @(negedge clk);
      chk(cfg_load == 1'b0, "R6 pulse one cycle", cfg_load, 0);
      bus_read(2'd3, r, oe);
      chk(r == w, "R4 readback", r, w);
      chk(pa_oe == {8{~w[4]}} && pb_oe == {8{~w[1]}} && pc_oe == {{4{~w[3]}}, {4{~w[0]}}},
          "R5 enables", {pa_oe, pb_oe, pc_oe}, {{8{~w[4]}}, {8{~w[1]}}, {4{~w[3]}}, {4{~w[0]}}});
      chk(mode_a == w[6:5] && mode_b == w[2], "R9 mode fields", {mode_a, mode_b}, {w[6:5], w[2]});
    end

    // R3: commit on release, select high ignored
    bus_write(2'd3, 8'h80, p);
    @(negedge clk); cs_n = 1'b0; addr = 2'd0; wdata = 8'h5A; wr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(pa_out == 8'h00, "R3 no change while write low", pa_out, 0);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    chk(pa_out == 8'h5A, "R3 commit on release", pa_out, 8'h5A);
    @(negedge clk); addr = 2'd0; wdata = 8'hFF; wr_n = 1'b0;
    @(negedge clk); @(negedge clk); wr_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(pa_out == 8'h5A, "R3 unselected write ignored", pa_out, 8'h5A);

    // R6: configuration clears latches
    bus_write(2'd1, 8'hC3, p);
    bus_write(2'd2, 8'h3C, p);
    bus_write(2'd3, 8'h80, p);
    chk(pa_out == 0 && pb_out == 0 && pc_out == 0, "R6 clear", {pa_out, pb_out, pc_out}, 0);

    // R7: all single-bit commands
    bus_write(2'd2, 8'hA5, p);
    pc_exp = 8'hA5;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] cmd;
      cmd = 8'(k);
      bus_write(2'd3, cmd, p);
      pc_exp[k >> 1] = cmd[0];
      chk(pc_out == pc_exp, "R7 bit command", pc_out, pc_exp);
      chk(p == 1'b0, "R7 no cfg_load", p, 0);
    end
    bus_read(2'd3, r, oe);
    chk(r == 8'h80, "R7 cfg unchanged", r, 8'h80);
    chk(pa_out == 0 && pb_out == 0, "R7 other ports unchanged", {pa_out, pb_out}, 0);

    // R8 R10: all direction combinations
    pa_in = 8'h96; pb_in = 8'h3C; pc_in = 8'hE1;
    for (int d = 0; d < 16; d++) begin
      logic [7:0] w, ea, eb, ec, ma, mb, mc;
      w  = 8'h80 | {3'b000, d[3], d[2], 1'b0, d[1], d[0]};
      ma = {8{~w[4]}}; mb = {8{~w[1]}}; mc = {{4{~w[3]}}, {4{~w[0]}}};
      bus_write(2'd3, w, p);
      bus_write(2'd0, 8'h5B, p);
      bus_write(2'd1, 8'hC7, p);
      bus_write(2'd2, 8'h2D, p);
      chk(pa_out == 8'h5B && pb_out == 8'hC7 && pc_out == 8'h2D, "R10 latch load",
          {pa_out, pb_out, pc_out}, 24'h5BC72D);
      ea = (8'h5B & ma) | (pa_in & ~ma);
      eb = (8'hC7 & mb) | (pb_in & ~mb);
      ec = (8'h2D & mc) | (pc_in & ~mc);
      bus_read(2'd0, ra, oe);
      bus_read(2'd1, rb, oe);
      bus_read(2'd2, rc, oe);
      chk(ra == ea, "R8 port A read", ra, ea);
      chk(rb == eb, "R8 port B read", rb, eb);
      chk(rc == ec, "R8 port C read", rc, ec);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule